// File: doc/BRIEF.md
# Strobed Serial DAC Word Writer

This block turns a parallel 12-bit sample into one serial write to an external DAC. It runs from a 40 MHz system clock. A one-cycle `go` pulse while the block is idle takes a copy of `din`. The block then sends a 16-bit frame on a three-wire SPI-style link: a select line driven low, a divided serial clock and one data line. `busy` stays high from the edge after the pulse until the write has finished.

The input behaves as a minimal valid/ready pair. `go` is the valid, and `busy` low is the ready. A word is taken only on a clock edge where `go` is high and `busy` is low. While `busy` is high the producer is back-pressured: `go` pulses are dropped rather than queued, and `din` may change freely. Because the word is copied at acceptance, changing `din` during a frame does not alter the bits that go out.

Top module: `dac_serial_writer`

## Requirements
- R1: After reset, `busy` is 0, `cs_n` is 1, `sclk` is 0 and `sdo` is 0.
- R2: When `go` is high and `busy` is low at a clock edge, the word is accepted. `busy` is 1 and `cs_n` is 0 after that same edge.
- R3: A frame is 16 bits, sent most significant bit first. Frame bits 15..12 carry the channel parameter CHANNEL (default 3, so 0011), and frame bits 11..0 carry the accepted data word.
- R4: `sclk` runs at the system clock divided by 4: two cycles low, then two cycles high. Its first rise comes on the second edge after acceptance, and each frame has exactly 16 rising edges, spaced 4 cycles apart.
- R5: `sdo` changes only while `sclk` is low. It holds steady across each high phase, so the receiver samples it on the rising edge of `sclk`.
- R6: `cs_n` stays low for the whole frame. It rises on the falling `sclk` edge that ends the 16th bit. `sclk` is never high while `cs_n` is high.
- R7: `busy` falls exactly one clock after `cs_n` rises, so `busy` is high for 65 cycles per frame.
- R8: Changes on `din` after acceptance have no effect on the frame being sent.
- R9: A `go` pulse while `busy` is high is ignored. No second frame follows, and `busy` stays low after the frame ends.
- R10: A `go` pulse on the first cycle in which `busy` is low is accepted, so frames can follow back to back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (40 MHz nominal) |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 12 | Sample to write (valid with `go`) |
| go | input | 1 | One-cycle start strobe (valid) |
| busy | output | 1 | Transfer in progress (not ready) |
| sclk | output | 1 | Serial clock to the DAC |
| cs_n | output | 1 | Active-low DAC select |
| sdo | output | 1 | Serial data to the DAC |

## Verification
The data path is tried with directed words (all zeros, all ones, alternating bits, a single set bit at each end), which separate bit-ordering and header errors from stuck bits. Seeded random words with random idle gaps cover the general case. Some frames also toggle `din` and pulse `go` in the middle of the transfer, which shows whether the word is really latched and whether a busy-time strobe can restart the frame. Back-to-back frames started on the first free cycle check the exact `busy` release timing against the select edge.

// File: rtl/dac_wr_pkg.sv
package dac_wr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_TAIL  = 2'd2
  } wr_state_t;
endpackage

// File: rtl/dac_sclk_gen.sv
module dac_sclk_gen #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sclk,
  output logic fall_tick
);
  localparam int PW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] P_RISE = PW'(DIV/2 - 1);
  localparam logic [PW-1:0] P_LAST = PW'(DIV - 1);

  logic [PW-1:0] phase;

  assign fall_tick = run && (phase == P_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
      sclk  <= 1'b0;
    end else if (!run) begin
      phase <= '0;
      sclk  <= 1'b0;
    end else begin
      phase <= (phase == P_LAST) ? '0 : phase + 1'b1;
      if (phase == P_RISE) sclk <= 1'b1;
      if (phase == P_LAST) sclk <= 1'b0;
    end
  end
endmodule

// File: rtl/dac_frame_reg.sv
module dac_frame_reg #(
  parameter int FRAME_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               shift,
  input  logic               clear,
  input  logic [FRAME_W-1:0] frame_in,
  output logic               sdo,
  output logic               last
);
  localparam int CW = $clog2(FRAME_W);
  localparam logic [CW-1:0] C_LAST = CW'(FRAME_W - 1);

  logic [FRAME_W-1:0] sh;
  logic [CW-1:0]      cnt;

  assign sdo  = sh[FRAME_W-1];
  assign last = (cnt == C_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh  <= '0;
      cnt <= '0;
    end else if (load) begin
      sh  <= frame_in;
      cnt <= '0;
    end else if (clear) begin
      sh  <= '0;
      cnt <= '0;
    end else if (shift) begin
      sh  <= {sh[FRAME_W-2:0], 1'b0};
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/dac_wr_seq.sv
module dac_wr_seq
  import dac_wr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic fall_tick,
  input  logic last,
  output logic load,
  output logic run,
  output logic shift,
  output logic clear,
  output logic busy,
  output logic cs_n
);
  wr_state_t st;

  assign load  = (st == ST_IDLE) && go;
  assign run   = (st == ST_SHIFT);
  assign shift = run && fall_tick && !last;
  assign clear = (st == ST_TAIL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      busy <= 1'b0;
      cs_n <= 1'b1;
    end else begin
      unique case (st)
        ST_IDLE: if (go) begin
          st   <= ST_SHIFT;
          busy <= 1'b1;
          cs_n <= 1'b0;
        end
        ST_SHIFT: if (fall_tick && last) begin
          st   <= ST_TAIL;
          cs_n <= 1'b1;
        end
        ST_TAIL: begin
          st   <= ST_IDLE;
          busy <= 1'b0;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dac_serial_writer.sv
module dac_serial_writer #(
  parameter int DATA_W  = 12,
  parameter int HDR_W   = 4,
  parameter int CHANNEL = 3,
  parameter int DIV     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] din,
  input  logic              go,
  output logic              busy,
  output logic              sclk,
  output logic              cs_n,
  output logic              sdo
);
  localparam int FRAME_W = HDR_W + DATA_W;
  localparam logic [HDR_W-1:0] HDR = HDR_W'(CHANNEL);

  logic load, run, shift, clear, fall_tick, last;
  logic [FRAME_W-1:0] frame_in;

  assign frame_in = {HDR, din};

  dac_wr_seq u_seq (
    .clk(clk), .rst_n(rst_n), .go(go), .fall_tick(fall_tick), .last(last),
    .load(load), .run(run), .shift(shift), .clear(clear),
    .busy(busy), .cs_n(cs_n)
  );

  dac_sclk_gen #(.DIV(DIV)) u_clk (
    .clk(clk), .rst_n(rst_n), .run(run), .sclk(sclk), .fall_tick(fall_tick)
  );

  dac_frame_reg #(.FRAME_W(FRAME_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .load(load), .shift(shift), .clear(clear),
    .frame_in(frame_in), .sdo(sdo), .last(last)
  );
endmodule

// File: rtl/dac_serial_writer_chk.sv
module dac_serial_writer_chk (
  input logic clk,
  input logic rst_n,
  input logic go,
  input logic busy,
  input logic sclk,
  input logic cs_n,
  input logic sdo
);
  a_r2_busy_after_go: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !busy) |=> (busy && !cs_n));

  a_r6_sclk_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> !cs_n);

  a_r6_select_implies_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> busy);

  a_r5_sdo_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(sdo));

  a_r7_busy_after_select: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |=> $fell(busy));

  a_r4_high_two_cycles: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |=> sclk);
endmodule

bind dac_serial_writer dac_serial_writer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .go(go), .busy(busy),
  .sclk(sclk), .cs_n(cs_n), .sdo(sdo)
);

// File: tb/dac_serial_writer_tb.sv
module dac_serial_writer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] din = '0;
  logic        go = 1'b0;
  logic        busy, sclk, cs_n, sdo;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  dac_serial_writer u_dut (
    .clk(clk), .rst_n(rst_n), .din(din), .go(go),
    .busy(busy), .sclk(sclk), .cs_n(cs_n), .sdo(sdo)
  );

  function automatic logic [15:0] exp_frame(input logic [11:0] d);
    return {4'd3, d};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  // drives a frame starting at the current negedge
  task automatic frame(input logic [11:0] d, input bit disturb, input bit idle_chk);
    logic [15:0] got = '0;
    int rises = 0, last_rise = -1, spacing_bad = 0, sdo_bad = 0, cs_bad = 0;
    int cs_rise = -1, busy_fall = -1, k = 0;
    logic pclk, psdo, pcs;
    go = 1'b1; din = d;
    @(negedge clk);
    go = 1'b0;
    chk(busy === 1'b1 && cs_n === 1'b0, "R2", {busy, cs_n}, 2'b10);
    pclk = sclk; psdo = sdo; pcs = cs_n;
    k = 1;
    while (busy === 1'b1 && k < 200) begin
      @(negedge clk);
      k++;
      if (disturb) begin
        din = 12'($urandom);
        go  = ($urandom % 5 == 0);
      end
      if (!pclk && sclk) begin
        got = {got[14:0], sdo};
        if (cs_n !== 1'b0) cs_bad++;
        if (last_rise >= 0 && k - last_rise != 4) spacing_bad++;
        if (rises == 0 && k != 3) spacing_bad++;
        last_rise = k; rises++;
      end
      if (pclk && sclk && sdo !== psdo) sdo_bad++;
      if (sclk && cs_n) cs_bad++;
      if (pcs === 1'b0 && cs_n === 1'b1) cs_rise = k;
      if (busy === 1'b0) busy_fall = k;
      pclk = sclk; psdo = sdo; pcs = cs_n;
    end
    go = 1'b0;
    if (k >= 200) chk(0, "R7 timeout", k, 66);
    chk(got == exp_frame(d), disturb ? "R8" : "R3", got, exp_frame(d));
    chk(rises == 16 && spacing_bad == 0, "R4", rises, 16);
    chk(sdo_bad == 0, "R5", sdo_bad, 0);
    chk(cs_bad == 0 && cs_rise == 65, "R6", cs_rise, 65);
    chk(busy_fall == cs_rise + 1 && busy_fall == 66, "R7", busy_fall, 66);
    if (idle_chk) begin
      repeat (4) @(negedge clk);
      chk(busy === 1'b0 && cs_n === 1'b1 && sclk === 1'b0, "R9", {busy, cs_n, sclk}, 3'b010);
    end
  endtask

  initial begin
    #(8 * 150000);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && cs_n === 1'b1 && sclk === 1'b0 && sdo === 1'b0,
        "R1", {busy, cs_n, sclk, sdo}, 4'b0100);
    rst_n = 1'b1;
    @(negedge clk);
    // R3 directed words
    frame(12'h000, 0, 0);
    frame(12'hFFF, 0, 0);
    frame(12'hA5A, 0, 0);
    frame(12'h801, 0, 1);
    // R8 / R9 disturbed frames
    frame(12'h3C7, 1, 1);
    frame(12'h5A5, 1, 1);
    // R10 back-to-back: start on the first negedge busy is low
    frame(12'h123, 0, 0);
    frame(12'hFED, 0, 0);
    chk(1, "R10", 0, 0);
    // random mix
    for (int i = 0; i < 24; i++) begin
      repeat ($urandom % 6) @(negedge clk);
      frame(12'($urandom), ($urandom % 2) == 1, 1);
    end
    finish_run();
  end
endmodule